// File: doc/BRIEF.md
# Host mailbox register block with byte FIFOs

This block sits between a host bus and a small embedded controller that talks one byte at a time. The host sees three 32-bit words: an interrupt control word, a data word and a status word. A write to the data word queues one byte toward the controller; a read of the data word takes the oldest byte the controller has sent. Each direction has its own eight-entry queue, so the host and the controller never have to run in lockstep.

The controller side is a plain push/pop port per queue. The status word shows the live level of both queues and a latched flag that records a byte lost because the receive queue was full. The interrupt word holds four request bits and four enable bits, one pair per status condition, and the block drives a single level interrupt whenever a condition is present and both of its bits are set. Host software typically writes 0x44 at start-up, arming the interrupt on received data, and writes the status value it just read back to the status word to clear the lost-byte flag.

Reads are combinational within the access cycle; every side effect (push, pop, register update, flag clear) takes place at the clock edge that ends the access.

Top module: `mbox_regs`

## Requirements
- R1: After reset both queues are empty, the interrupt word reads 0, the status word reads 0x3, `irq` is low and `mcu_tx_valid` is low.
- R2: Word index 0 is the interrupt word, 1 the data word (byte offset 0x4), 2 the status word (byte offset 0x8); indices 3 to 7 read as zero and writes to them change nothing.
- R3: A data-word write queues `bus_wdata[15:8]` for the controller; the controller receives bytes on `mcu_tx_data` in write order, with `mcu_tx_valid` high while any remain.
- R4: A data-word read removes the oldest received byte and returns it in bits 15:8, every other bit zero; a read with nothing received returns 0 and loses no later byte.
- R5: Each queue holds 8 bytes; a data-word write while the transmit queue holds 8 is discarded.
- R6: Status bit 0 is transmit-empty, bit 1 transmit-not-full, bit 2 receive-not-empty, bit 3 the lost-byte flag; bits 31:4 read zero.
- R7: A controller push while the receive queue holds 8 discards the byte and sets status bit 3; the flag stays set until a status write with bit 3 equal to 1, and status writes with bit 3 equal to 0 leave it set.
- R8: Interrupt word bits 3:0 are request bits and bits 7:4 enable bits, both in status-bit order; the eight bits read back as written and bits 31:8 read zero.
- R9: `irq` equals the OR over the four conditions of status bit AND request bit AND enable bit.
- R10: With the interrupt word set to 0x44, `irq` rises in the cycle after the controller pushes a byte into an empty receive queue and falls after the host reads that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_word | input | 3 | Word index (byte address bits 4:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| mcu_tx_pop | input | 1 | Controller takes the head transmit byte |
| mcu_tx_data | output | 8 | Head transmit byte, 0 when empty |
| mcu_tx_valid | output | 1 | Transmit queue holds a byte |
| mcu_rx_push | input | 1 | Controller offers a byte to the host |
| mcu_rx_data | input | 8 | Byte offered by the controller |
| irq | output | 1 | Level interrupt to the host |

## Verification
The queues are filled from zero to one past capacity in both directions with byte values computed from the index, which separates ordering faults, wrong byte lanes and an off-by-one capacity. The lost-byte flag is set and then hit with status writes of 0, of the other three bits and finally of bit 3, telling a sticky flag from a live one and a write-one-clear from a plain write. The interrupt word is swept through all 256 values in three queue states, so every request/enable/status combination is compared against the arithmetic OR-of-ANDs. The reserved words are written with all ones and read back, showing that the decode neither aliases nor leaks.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int WORD_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int NCOND    = 4;
  localparam int INDEX_W  = 3;

  localparam logic [INDEX_W-1:0] IDX_IRQ  = 3'd0;
  localparam logic [INDEX_W-1:0] IDX_DATA = 3'd1;
  localparam logic [INDEX_W-1:0] IDX_STAT = 3'd2;

  // status / condition bit order, shared by the interrupt word
  localparam int C_TX_EMPTY = 0;
  localparam int C_TX_ROOM  = 1;
  localparam int C_RX_AVAIL = 2;
  localparam int C_RX_LOST  = 3;

  function automatic logic [WORD_W-1:0] lane_put(input logic [BYTE_W-1:0] b);
    return {{(WORD_W-2*BYTE_W){1'b0}}, b, {BYTE_W{1'b0}}};
  endfunction

  function automatic logic [BYTE_W-1:0] lane_get(input logic [WORD_W-1:0] w);
    return w[2*BYTE_W-1:BYTE_W];
  endfunction

  function automatic logic irq_of(input logic [NCOND-1:0] cond,
                                  input logic [2*NCOND-1:0] ctl);
    return |(cond & ctl[NCOND-1:0] & ctl[2*NCOND-1:NCOND]);
  endfunction
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         push_drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH-1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (count == '0);
  assign full      = (count == FULL_CNT);
  assign push_ok   = push && !full;
  assign pop_ok    = pop && !empty;
  assign push_drop = push && full;
  assign head      = empty ? '0 : mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= step(wptr);
      if (pop_ok)  rptr <= step(rptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  p_full_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (full && $stable(wptr)));
  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> (empty && $stable(rptr)));
endmodule

// File: rtl/mbox_irq_ctl.sv
module mbox_irq_ctl
  import mbox_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_we,
  input  logic [2*NCOND-1:0] ctl_wdata,
  input  logic               clr_we,
  input  logic [NCOND-1:0]   clr_bits,
  input  logic               lost_event,
  input  logic               tx_empty,
  input  logic               tx_full,
  input  logic               rx_empty,
  output logic [2*NCOND-1:0] ctl_q,
  output logic [NCOND-1:0]   cond,
  output logic               irq
);
  logic lost_q;
  logic lost_clr;

  assign lost_clr = clr_we && clr_bits[C_RX_LOST];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      if (ctl_we) ctl_q <= ctl_wdata;
      if (lost_event)    lost_q <= 1'b1;   // a new loss wins over a clear
      else if (lost_clr) lost_q <= 1'b0;
    end
  end

  always_comb begin
    cond             = '0;
    cond[C_TX_EMPTY] = tx_empty;
    cond[C_TX_ROOM]  = !tx_full;
    cond[C_RX_AVAIL] = !rx_empty;
    cond[C_RX_LOST]  = lost_q;
  end

  assign irq = irq_of(cond, ctl_q);

  p_lost_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_q && !lost_clr) |=> lost_q);
  p_lost_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lost_event |=> lost_q);
  p_irq_needs_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(ctl_q[NCOND-1:0] & ctl_q[2*NCOND-1:NCOND]));
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
  import mbox_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [INDEX_W-1:0]  bus_word,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic                mcu_tx_pop,
  output logic [BYTE_W-1:0]   mcu_tx_data,
  output logic                mcu_tx_valid,
  input  logic                mcu_rx_push,
  input  logic [BYTE_W-1:0]   mcu_rx_data,
  output logic                irq
);
  logic sel_irq, sel_data, sel_stat;
  logic tx_push, rx_pop;
  logic tx_empty, tx_full, tx_drop;
  logic rx_empty, rx_full, rx_drop;
  logic [BYTE_W-1:0]  rx_head;
  logic [2*NCOND-1:0] ctl_q;
  logic [NCOND-1:0]   cond;
  logic unused_wdata_hi;

  assign sel_irq  = (bus_word == IDX_IRQ);
  assign sel_data = (bus_word == IDX_DATA);
  assign sel_stat = (bus_word == IDX_STAT);
  assign tx_push  = bus_wr && sel_data;
  assign rx_pop   = bus_rd && sel_data;
  assign unused_wdata_hi = ^{bus_wdata[WORD_W-1:2*BYTE_W], tx_drop, rx_full};

  mbox_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .push_data(lane_get(bus_wdata)),
    .pop(mcu_tx_pop), .head(mcu_tx_data),
    .empty(tx_empty), .full(tx_full), .push_drop(tx_drop)
  );

  mbox_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .push(mcu_rx_push), .push_data(mcu_rx_data),
    .pop(rx_pop), .head(rx_head),
    .empty(rx_empty), .full(rx_full), .push_drop(rx_drop)
  );

  mbox_irq_ctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(bus_wr && sel_irq), .ctl_wdata(bus_wdata[2*NCOND-1:0]),
    .clr_we(bus_wr && sel_stat), .clr_bits(bus_wdata[NCOND-1:0]),
    .lost_event(rx_drop),
    .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty),
    .ctl_q(ctl_q), .cond(cond), .irq(irq)
  );

  assign mcu_tx_valid = !tx_empty;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel_irq)       bus_rdata = {{(WORD_W-2*NCOND){1'b0}}, ctl_q};
      else if (sel_data) bus_rdata = lane_put(rx_head);
      else if (sel_stat) bus_rdata = {{(WORD_W-NCOND){1'b0}}, cond};
    end
  end

  p_data_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> (bus_rdata[WORD_W-1:2*BYTE_W] == '0 && bus_rdata[BYTE_W-1:0] == '0));
  p_idle_bus_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));
  p_tx_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && !tx_full) |=> mcu_tx_valid);
  p_rx_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_rx_push && ctl_q[C_RX_AVAIL] && ctl_q[NCOND+C_RX_AVAIL] && !bus_wr) |=> irq);
endmodule

// File: tb/sim_mbox_regs.sv
module sim_mbox_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_word = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mcu_tx_pop = 1'b0;
  logic [7:0]  mcu_tx_data;
  logic        mcu_tx_valid;
  logic        mcu_rx_push = 1'b0;
  logic [7:0]  mcu_rx_data = '0;
  logic        irq;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  mbox_regs u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] w, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_word = w; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] w, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_word = w;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk); mcu_rx_push = 1'b1; mcu_rx_data = b;
    @(posedge clk); #1 mcu_rx_push = 1'b0;
  endtask

  task automatic pop_tx(output logic [7:0] b, output logic v);
    @(negedge clk); mcu_tx_pop = 1'b1;
    #1 b = mcu_tx_data; v = mcu_tx_valid;
    @(posedge clk); #1 mcu_tx_pop = 1'b0;
  endtask

  function automatic logic [31:0] stat_of(input int txn, input int rxn, input logic lost);
    return {28'd0, lost, rxn != 0, txn != 8, txn == 0};
  endfunction

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 29 + i * 53 + 7) % 256);
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  b;
    logic        v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(3'd2, d); chk("R1 status", d, 32'h3);
    rd(3'd0, d); chk("R1 intr", d, 32'h0);
    #1 chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 tx_valid", {31'd0, mcu_tx_valid}, 32'd0);

    // R2 reserved words
    for (int w = 3; w < 8; w++) begin
      wr(3'(w), 32'hFFFF_FFFF);
      rd(3'(w), d); chk("R2 reserved read", d, 32'h0);
    end
    rd(3'd0, d); chk("R2 intr untouched", d, 32'h0);
    rd(3'd2, d); chk("R2 status untouched", d, 32'h3);

    // R3 R5 R6 transmit fill sweep 0..9
    for (int n = 0; n <= 9; n++) begin
      for (int i = 0; i < n; i++) begin
        wr(3'd1, {8'hA5, 8'h3C, pat(n, i), 8'h5A});
        rd(3'd2, d); chk("R6 tx status", d, stat_of((i + 1 > 8) ? 8 : i + 1, 0, 1'b0));
      end
      for (int i = 0; i < ((n > 8) ? 8 : n); i++) begin
        pop_tx(b, v);
        chk("R3 tx order", {24'd0, b}, {24'd0, pat(n, i)});
        chk("R3 tx valid", {31'd0, v}, 32'd1);
      end
      pop_tx(b, v);
      chk("R5 tx drained", {23'd0, v, b}, 32'd0);
    end

    // R4 receive sweep, with empty reads between
    rd(3'd1, d); chk("R4 empty read", d, 32'h0);
    for (int n = 1; n <= 8; n++) begin
      for (int i = 0; i < n; i++) push_rx(pat(n + 40, i));
      rd(3'd2, d); chk("R6 rx status", d, stat_of(0, n, 1'b0));
      for (int i = 0; i < n; i++) begin
        rd(3'd1, d); chk("R4 rx byte", d, {16'd0, pat(n + 40, i), 8'd0});
      end
      rd(3'd1, d); chk("R4 empty after drain", d, 32'h0);
    end

    // R7 overflow
    for (int i = 0; i < 9; i++) push_rx(pat(77, i));
    rd(3'd2, d); chk("R7 lost set", d, stat_of(0, 8, 1'b1));
    for (int i = 0; i < 8; i++) begin
      rd(3'd1, d); chk("R7 kept bytes", d, {16'd0, pat(77, i), 8'd0});
    end
    rd(3'd1, d); chk("R7 dropped byte absent", d, 32'h0);
    wr(3'd2, 32'h0);
    rd(3'd2, d); chk("R7 zero write keeps", d, stat_of(0, 0, 1'b1));
    wr(3'd2, 32'h7);
    rd(3'd2, d); chk("R7 other bits keep", d, stat_of(0, 0, 1'b1));
    wr(3'd2, 32'hB);
    rd(3'd2, d); chk("R7 w1c clears", d, stat_of(0, 0, 1'b0));

    // R8 interrupt word read/write
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d); chk("R8 intr mask", d, 32'hFF);
    wr(3'd0, 32'h0000_005A);
    rd(3'd0, d); chk("R8 intr value", d, 32'h5A);

    // R9 exhaustive interrupt sweep over three queue states
    for (int s = 0; s < 3; s++) begin
      logic [3:0] st;
      if (s == 1) push_rx(8'h11);
      if (s == 2) begin
        for (int i = 0; i < 8; i++) push_rx(8'h22);
        for (int i = 0; i < 8; i++) wr(3'd1, 32'h0000_3300);
      end
      rd(3'd2, d); st = d[3:0];
      chk("R9 state status", d, (s == 0) ? stat_of(0, 0, 1'b0) :
                                (s == 1) ? stat_of(0, 1, 1'b0) : stat_of(8, 8, 1'b1));
      for (int c = 0; c < 256; c++) begin
        logic [7:0] cv;
        cv = 8'(c);
        wr(3'd0, {24'd0, cv});
        chk("R9 irq", {31'd0, irq}, {31'd0, |(st & cv[3:0] & cv[7:4])});
      end
    end

    // R10 start-up arming sequence
    rst_n = 1'b0; @(posedge clk); #1 rst_n = 1'b1;
    wr(3'd0, 32'h44);
    chk("R10 idle irq low", {31'd0, irq}, 32'd0);
    push_rx(8'hC3);
    chk("R10 irq rises", {31'd0, irq}, 32'd1);
    rd(3'd1, d); chk("R10 byte", d, 32'h0000_C300);
    chk("R10 irq falls", {31'd0, irq}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule